// File: doc/BRIEF.md
# Image Sensor Readout Timing Generator

This block sequences the readout of a CMOS pixel array. The array has a Bayer-patterned active area and an optically shielded border that covers the leading rows and columns. Rows are scanned as a rolling pair. In the cycle just before a row's pixels come out, the block strobes that row for transfer to the sampling stage. In the same cycle it names a second row, a programmable integration distance ahead, for reset. The transferred row is then shifted out one pixel per clock, starting at column 0.

For every output pixel the block gives the row and column counters, a shielded-border flag and a 2-bit colour tag. Framing is carried by a line-valid qualifier and a frame-valid qualifier. Horizontal and vertical blanking lengths are programmable. Frames run back to back while the continuous-run input is held high. A single-cycle snapshot pulse taken in idle captures exactly one frame. A one-cycle completion pulse follows the last pixel of every frame.

Top module: `sensor_readout_tg`

## Requirements
- R1: While reset is held, and in idle after reset, line_valid_o, frame_valid_o, row_stb_o and done_o are all low.
- R2: A frame delivers rows 0 to NROWS-1 in order. Each row shows columns 0 to NCOLS-1 on consecutive cycles, with line_valid_o high for exactly NCOLS cycles.
- R3: Between two rows of one frame, line_valid_o is low for exactly max(hblank_i,1) cycles and frame_valid_o stays high.
- R4: frame_valid_o is high whenever line_valid_o is high, and stays high from the first pixel of row 0 to the last pixel of row NROWS-1. In continuous mode it is low for exactly max(vblank_i,1) cycles between frames.
- R5: During line_valid_o, black_o is 1 exactly when row < BLK_ROWS or col < BLK_COLS, and color_o is then 2'b00.
- R6: For active pixels, let the relative row parity be (row-BLK_ROWS) mod 2 and the column parity be (col-BLK_COLS) mod 2. color_o is 00 for green on an even relative row, 01 for red on an even relative row, 10 for blue on an odd relative row and 11 for green on an odd relative row.
- R7: row_stb_o is high for exactly the one cycle before each row's first pixel, and xfer_row_o then equals that row.
- R8: While row_stb_o is high, rst_row_o equals (xfer_row_o + min(integ_rows_i, NROWS-1)) mod NROWS.
- R9: Suppose snap_i is high at one clock edge while the block is idle and run_i is low. Then row_stb_o is high in the next cycle and the first pixel (row 0, column 0) appears in the cycle after that. Exactly one frame follows.
- R10: done_o is a one-cycle pulse in the cycle right after the last pixel of each frame, and is low at all other times.
- R11: snap_i has no effect while a frame is in progress. After a single frame ends with run_i low, line_valid_o stays low until a new trigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Continuous frame mode while high |
| snap_i | input | 1 | Single-frame capture trigger, taken in idle |
| integ_rows_i | input | RW | Integration distance in rows between reset and readout |
| hblank_i | input | BW | Blanking cycles between rows (0 counts as 1) |
| vblank_i | input | BW | Blanking cycles between continuous frames (0 counts as 1) |
| row_o | output | RW | Row of the current pixel |
| col_o | output | CW | Column of the current pixel |
| line_valid_o | output | 1 | High during the pixels of a row |
| frame_valid_o | output | 1 | High from the first to the last row of a frame |
| black_o | output | 1 | Current pixel lies in the shielded border |
| color_o | output | 2 | Bayer colour tag of the current pixel |
| row_stb_o | output | 1 | Row transfer and row reset strobe |
| xfer_row_o | output | RW | Row transferred during row_stb_o |
| rst_row_o | output | RW | Row reset during row_stb_o |
| done_o | output | 1 | Frame completion pulse |

## Verification
The bench goes after blanking values of zero. A design that skipped the one-cycle minimum would merge two rows or drop the transfer slot, and line_valid_o would stay high across the row boundary. It checks the colour phase at the border edge, where a design that took parity from the absolute row or column would swap red and blue or the two greens. It checks an integration value above the row count, which exposes a missing clamp or wrap in the reset pointer. It also pulses a snapshot in the middle of a frame, and a design that latched that pulse would start a second frame after done_o.

// File: rtl/sensor_tg_pkg.sv
package sensor_tg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_LINE = 2'd2
  } seq_st_e;

  localparam logic [1:0] TAG_GR    = 2'b00;
  localparam logic [1:0] TAG_R     = 2'b01;
  localparam logic [1:0] TAG_B     = 2'b10;
  localparam logic [1:0] TAG_GB    = 2'b11;
  localparam logic [1:0] TAG_BLACK = 2'b00;
endpackage

// File: rtl/tg_line_seq.sv
module tg_line_seq
  import sensor_tg_pkg::*;
#(
  parameter int NROWS = 496,
  parameter int NCOLS = 656,
  parameter int BW    = 8,
  localparam int RW   = $clog2(NROWS),
  localparam int CW   = $clog2(NCOLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          snap_i,
  input  logic [BW-1:0] hblank_i,
  input  logic [BW-1:0] vblank_i,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          line_valid_o,
  output logic          frame_valid_o,
  output logic          row_stb_o,
  output logic          done_o
);
  seq_st_e       st_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [BW-1:0] gap_q;
  logic          vgap_q;
  logic          done_q;
  logic [BW-1:0] hlen, vlen;

  // zero blanking still leaves one slot for the row strobe
  assign hlen = (hblank_i == '0) ? BW'(1) : hblank_i;
  assign vlen = (vblank_i == '0) ? BW'(1) : vblank_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      row_q  <= '0;
      col_q  <= '0;
      gap_q  <= '0;
      vgap_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (run_i || snap_i) begin
            st_q   <= ST_GAP;
            gap_q  <= BW'(1);
            vgap_q <= 1'b1;
            row_q  <= '0;
            col_q  <= '0;
          end
        end
        ST_GAP: begin
          if (gap_q == BW'(1)) st_q <= ST_LINE;
          else gap_q <= gap_q - BW'(1);
        end
        ST_LINE: begin
          if (col_q == CW'(NCOLS - 1)) begin
            col_q <= '0;
            if (row_q == RW'(NROWS - 1)) begin
              row_q  <= '0;
              done_q <= 1'b1;
              vgap_q <= 1'b1;
              if (run_i) begin
                st_q  <= ST_GAP;
                gap_q <= vlen;
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              row_q  <= row_q + RW'(1);
              st_q   <= ST_GAP;
              gap_q  <= hlen;
              vgap_q <= 1'b0;
            end
          end else begin
            col_q <= col_q + CW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign row_o         = row_q;
  assign col_o         = col_q;
  assign line_valid_o  = (st_q == ST_LINE);
  assign frame_valid_o = (st_q == ST_LINE) || ((st_q == ST_GAP) && !vgap_q);
  assign row_stb_o     = (st_q == ST_GAP) && (gap_q == BW'(1));
  assign done_o        = done_q;
endmodule

// File: rtl/tg_roll_ptr.sv
module tg_roll_ptr #(
  parameter int NROWS = 496,
  localparam int RW   = $clog2(NROWS)
) (
  input  logic [RW-1:0] row_i,
  input  logic [RW-1:0] integ_i,
  output logic [RW-1:0] rst_row_o
);
  logic [RW-1:0] integ_eff;
  logic [RW:0]   sum;

  assign integ_eff = (integ_i > RW'(NROWS - 1)) ? RW'(NROWS - 1) : integ_i;
  assign sum       = {1'b0, row_i} + {1'b0, integ_eff};

  always_comb begin
    if (sum >= (RW+1)'(NROWS)) rst_row_o = RW'(sum - (RW+1)'(NROWS));
    else rst_row_o = sum[RW-1:0];
  end
endmodule

// File: rtl/tg_bayer_tag.sv
module tg_bayer_tag
  import sensor_tg_pkg::*;
#(
  parameter int NROWS    = 496,
  parameter int NCOLS    = 656,
  parameter int BLK_ROWS = 8,
  parameter int BLK_COLS = 8,
  localparam int RW      = $clog2(NROWS),
  localparam int CW      = $clog2(NCOLS)
) (
  input  logic          valid_i,
  input  logic [RW-1:0] row_i,
  input  logic [CW-1:0] col_i,
  output logic          black_o,
  output logic [1:0]    color_o
);
  localparam logic ROW_PH = 1'(BLK_ROWS % 2);
  localparam logic COL_PH = 1'(BLK_COLS % 2);

  logic in_border, row_par, col_par;

  assign in_border = (row_i < RW'(BLK_ROWS)) || (col_i < CW'(BLK_COLS));
  // parity relative to the first active row and column
  assign row_par   = row_i[0] ^ ROW_PH;
  assign col_par   = col_i[0] ^ COL_PH;

  always_comb begin
    black_o = valid_i && in_border;
    if (!valid_i || in_border) color_o = TAG_BLACK;
    else if (!row_par)         color_o = col_par ? TAG_R  : TAG_GR;
    else                       color_o = col_par ? TAG_GB : TAG_B;
  end
endmodule

// File: rtl/sensor_readout_tg.sv
module sensor_readout_tg #(
  parameter int BLK_ROWS = 8,
  parameter int BLK_COLS = 8,
  parameter int ACT_ROWS = 488,
  parameter int ACT_COLS = 648,
  parameter int BW       = 8,
  localparam int NROWS   = BLK_ROWS + ACT_ROWS,
  localparam int NCOLS   = BLK_COLS + ACT_COLS,
  localparam int RW      = $clog2(NROWS),
  localparam int CW      = $clog2(NCOLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          snap_i,
  input  logic [RW-1:0] integ_rows_i,
  input  logic [BW-1:0] hblank_i,
  input  logic [BW-1:0] vblank_i,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          line_valid_o,
  output logic          frame_valid_o,
  output logic          black_o,
  output logic [1:0]    color_o,
  output logic          row_stb_o,
  output logic [RW-1:0] xfer_row_o,
  output logic [RW-1:0] rst_row_o,
  output logic          done_o
);
  logic [RW-1:0] row_w;
  logic [CW-1:0] col_w;
  logic          lv_w;

  tg_line_seq #(.NROWS(NROWS), .NCOLS(NCOLS), .BW(BW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .snap_i       (snap_i),
    .hblank_i     (hblank_i),
    .vblank_i     (vblank_i),
    .row_o        (row_w),
    .col_o        (col_w),
    .line_valid_o (lv_w),
    .frame_valid_o(frame_valid_o),
    .row_stb_o    (row_stb_o),
    .done_o       (done_o)
  );

  tg_roll_ptr #(.NROWS(NROWS)) u_ptr (
    .row_i    (row_w),
    .integ_i  (integ_rows_i),
    .rst_row_o(rst_row_o)
  );

  tg_bayer_tag #(
    .NROWS(NROWS), .NCOLS(NCOLS), .BLK_ROWS(BLK_ROWS), .BLK_COLS(BLK_COLS)
  ) u_tag (
    .valid_i(lv_w),
    .row_i  (row_w),
    .col_i  (col_w),
    .black_o(black_o),
    .color_o(color_o)
  );

  assign row_o        = row_w;
  assign col_o        = col_w;
  assign xfer_row_o   = row_w;
  assign line_valid_o = lv_w;
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
  parameter int NROWS = 496,
  parameter int NCOLS = 656,
  localparam int RW   = $clog2(NROWS),
  localparam int CW   = $clog2(NCOLS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [RW-1:0] row_o,
  input logic [CW-1:0] col_o,
  input logic          line_valid_o,
  input logic          frame_valid_o,
  input logic          black_o,
  input logic [1:0]    color_o,
  input logic          row_stb_o,
  input logic [RW-1:0] xfer_row_o,
  input logic [RW-1:0] rst_row_o,
  input logic          done_o
);
  assert_line_in_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> frame_valid_o);

  assert_col_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_o && col_o != CW'(NCOLS - 1)) |=>
      (line_valid_o && col_o == $past(col_o) + CW'(1) && row_o == $past(row_o)));

  assert_stb_then_line_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_stb_o |=> (line_valid_o && col_o == '0 && row_o == $past(xfer_row_o)));

  assert_stb_not_in_line_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_stb_o |-> !line_valid_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_last_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(line_valid_o) && $past(row_o) == RW'(NROWS - 1)
                       && $past(col_o) == CW'(NCOLS - 1)));

  assert_black_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_o && black_o) |-> (color_o == 2'b00));

  assert_rst_ptr_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_stb_o |-> (rst_row_o < RW'(NROWS)));
endmodule

bind sensor_readout_tg tg_checker #(.NROWS(NROWS), .NCOLS(NCOLS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .row_o        (row_o),
  .col_o        (col_o),
  .line_valid_o (line_valid_o),
  .frame_valid_o(frame_valid_o),
  .black_o      (black_o),
  .color_o      (color_o),
  .row_stb_o    (row_stb_o),
  .xfer_row_o   (xfer_row_o),
  .rst_row_o    (rst_row_o),
  .done_o       (done_o)
);

// File: tb/sim_sensor_readout_tg.sv
`timescale 1ns/1ps
module sim_sensor_readout_tg;
  localparam int BR = 2, BC = 2, AR = 4, AC = 6, BW = 8;
  localparam int NR = BR + AR, NC = BC + AC;
  localparam int RW = $clog2(NR), CW = $clog2(NC);

  logic clk = 1'b0, rst_ni = 1'b0, run = 1'b0, snap = 1'b0;
  logic [RW-1:0] integ = '0;
  logic [BW-1:0] hb = '0, vb = '0;
  logic [RW-1:0] row, xrow, rrow;
  logic [CW-1:0] col;
  logic lv, fv, blk, stb, done;
  logic [1:0] clr;

  always #2 clk = ~clk;

  sensor_readout_tg #(.BLK_ROWS(BR), .BLK_COLS(BC), .ACT_ROWS(AR), .ACT_COLS(AC), .BW(BW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run), .snap_i(snap), .integ_rows_i(integ),
    .hblank_i(hb), .vblank_i(vb), .row_o(row), .col_o(col), .line_valid_o(lv),
    .frame_valid_o(fv), .black_o(blk), .color_o(clr), .row_stb_o(stb),
    .xfer_row_o(xrow), .rst_row_o(rrow), .done_o(done));

  int n_checks = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int min1(input int v); return (v == 0) ? 1 : v; endfunction
  function automatic bit exp_black(input int r, input int c); return (r < BR) || (c < BC); endfunction
  function automatic int exp_color(input int r, input int c);
    int rp, cp;
    if (exp_black(r, c)) return 0;
    rp = (r - BR) % 2; cp = (c - BC) % 2;
    if (rp == 0) return (cp == 0) ? 0 : 1;
    return (cp == 0) ? 2 : 3;
  endfunction
  function automatic int exp_rst(input int r, input int ig);
    int e;
    e = (ig > NR - 1) ? NR - 1 : ig;
    return (r + e) % NR;
  endfunction

  // monitor state
  bit mon_en = 0, idle_expect = 0, exp_done = 0, vgap_chk = 0;
  bit pend_stb = 0;
  int pend_row = 0, pend_rst = 0;
  int exp_row = 0, exp_col = 0, lv_low = 0, fv_low = 0;

  always @(negedge clk) if (mon_en) begin
    chk(done == exp_done, "R10 done pulse", int'(done), int'(exp_done));
    exp_done = 0;
    chk(pend_stb == (lv && exp_col == 0), "R7 strobe placement", int'(pend_stb), int'(lv && exp_col == 0));
    if (lv) begin
      chk(!idle_expect, "R11 no frame after single capture", 1, 0);
      if (exp_col == 0) begin
        chk(pend_row == exp_row, "R7 transfer row", pend_row, exp_row);
        chk(pend_rst == exp_rst(exp_row, int'(integ)), "R8 reset pointer", pend_rst, exp_rst(exp_row, int'(integ)));
        if (exp_row != 0) chk(lv_low == min1(int'(hb)), "R3 line blanking", lv_low, min1(int'(hb)));
        else if (vgap_chk) chk(fv_low == min1(int'(vb)), "R4 frame blanking", fv_low, min1(int'(vb)));
      end
      chk(int'(row) == exp_row, "R2 row order", int'(row), exp_row);
      chk(int'(col) == exp_col, "R2 column order", int'(col), exp_col);
      chk(fv, "R4 frame valid during line", int'(fv), 1);
      chk(blk == exp_black(exp_row, exp_col), "R5 black flag", int'(blk), int'(exp_black(exp_row, exp_col)));
      chk(int'(clr) == exp_color(exp_row, exp_col), "R6 colour tag", int'(clr), exp_color(exp_row, exp_col));
      if (exp_col == NC - 1) begin
        exp_col = 0;
        if (exp_row == NR - 1) begin
          exp_row = 0; exp_done = 1; vgap_chk = run;
        end else exp_row++;
      end else exp_col++;
      lv_low = 0; fv_low = 0;
    end else begin
      chk(exp_col == 0, "R2 row cut short", exp_col, 0);
      if (exp_row != 0) chk(fv, "R3 frame valid in line gap", int'(fv), 1);
      lv_low++;
      if (!fv) fv_low++;
    end
    pend_stb = stb; pend_row = int'(xrow); pend_rst = int'(rrow);
  end

  task automatic snap_frame();
    @(posedge clk); #1 snap = 1'b1;
    @(posedge clk); #1 snap = 1'b0;
    @(negedge clk); #0.1;
    chk(stb && !lv, "R9 strobe one cycle after trigger", int'(stb), 1);
    @(negedge clk); #0.1;
    chk(lv && row == '0 && col == '0, "R9 first pixel two cycles after trigger", int'(lv), 1);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic idle_window(input int n);
    idle_expect = 1;
    repeat (n) @(negedge clk);
    chk(!lv && !fv, "R11 idle after frame", int'(lv), 0);
    idle_expect = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!lv && !fv && !stb && !done, "R1 outputs low in reset", int'(lv | fv | stb | done), 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!lv && !fv && !stb && !done, "R1 outputs low in idle", int'(lv | fv | stb | done), 0);
    mon_en = 1;

    // directed: snapshot, with a second pulse mid-frame that must be ignored
    hb = 8'd3; vb = 8'd4; integ = 3'd2;
    snap_frame();
    repeat (20) @(posedge clk);
    #1 snap = 1'b1; @(posedge clk); #1 snap = 1'b0;
    wait_done();
    idle_window(30);

    // directed: zero blanking and integration above row count
    hb = 8'd0; integ = 3'd7;
    snap_frame();
    wait_done();
    idle_window(20);

    // random continuous runs
    for (int it = 0; it < 5; it++) begin
      hb = 8'($urandom_range(0, 6));
      vb = 8'($urandom_range(0, 9));
      integ = 3'($urandom_range(0, 7));
      @(posedge clk); #1 run = 1'b1;
      wait_done();
      wait_done();
      @(posedge clk); #1 run = 1'b0;
      wait_done();
      idle_window(15);
    end

    // directed: zero vertical blanking in continuous mode
    hb = 8'd1; vb = 8'd0; integ = 3'd5;
    @(posedge clk); #1 run = 1'b1;
    wait_done();
    wait_done();
    @(posedge clk); #1 run = 1'b0;
    wait_done();
    idle_window(10);

    summary();
    $finish;
  end
endmodule